// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block sits behind the control pins of a DDR3-style memory device. On every rising clock edge it samples chip select, the three command strobes, clock enable, the termination request, the bank bits and the address bus. It turns them into one decoded command per cycle: bank activation, column read or write, bank close (one bank or all of them), mode register load, refresh, no-operation or deselect. Each decoded command comes with the fields it needs: bank, row or opcode, column, an auto-close flag, a close-all flag and a four-beat chop flag.

The address bus changes meaning with the command. Bit 10 is the auto-close flag on column accesses and the close-all flag on bank close. Bit 12 picks the burst chop on column accesses when the mode register allows an on-the-fly choice. On a mode load, the bank bits pick one of four stored mode registers. The block keeps a per-bank open-row bit and uses it to report which kind of power-down clock enable has entered. It also drives a registered termination-enable output, which can be switched off through a mode register.

Top module: `ddr_cmd_decode`

## Requirements
- R1: While `rst_n` is low, and until the first command edge after it rises, every output is zero: command code 0, all fields 0, all open-row bits clear, all mode registers 0, power-down code 0, termination off.
- R2: When chip select is sampled high in an accepted cycle, `cmd_kind` is 1 (deselect), every field is 0, and neither the mode registers nor the open-row bits change.
- R3: In an accepted cycle with chip select low, {ras_n,cas_n,we_n} decodes as 000 load mode (code 7), 001 refresh (6), 010 bank close (5), 011 activate (2), 100 write (4), 101 read (3), 110 and 111 no-operation (0). Refresh and no-operation carry all-zero fields.
- R4: Activate reports `cmd_bank` = bank bits and `cmd_addr` = address bus, and sets that bank's open-row bit.
- R5: Bank close with address bit 10 low reports `cmd_all` = 0 and clears only the open-row bit of the given bank. With bit 10 high it reports `cmd_all` = 1 and clears every open-row bit.
- R6: Read and write report `cmd_bank`, `cmd_col` = address bits [9:0] and `cmd_ap` = address bit 10. When bit 10 is high, that bank's open-row bit is cleared.
- R7: The burst field of mode register 0 (bits [1:0]) sets `cmd_bc4` on reads and writes: 00 and 11 give 0, 10 gives 1, and 01 gives the inverse of address bit 12. Bit 12 has no effect in the other settings.
- R8: Load mode stores the address bus into mode register number {ba[1:0]}, and reports `cmd_bank` = bank bits and `cmd_addr` = address bus. The stored value is visible on `mode_regs` from the same edge, and it governs burst and termination from the following cycle.
- R9: When clock enable is sampled low while not in power-down, `pd_mode` becomes 1 if every open-row bit is clear and 2 if any is set. When clock enable is sampled high, `pd_mode` becomes 0. It holds otherwise.
- R10: A cycle is accepted only if clock enable is high and `pd_mode` is 0 before the edge. Every other cycle, including the exit cycle, reports code 0 and changes no mode register and no open-row bit.
- R11: `odt_en` is the sampled `odt` ANDed with the termination setting of mode register 1 (bits 9, 6 or 2 nonzero), taken from the value held before the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| odt | input | 1 | Termination request |
| ba | input | BA_W | Bank address / mode register select |
| addr | input | ADDR_W | Row, column, flags or opcode |
| cmd_kind | output | 3 | Decoded command code |
| cmd_bank | output | BA_W | Bank of the decoded command |
| cmd_addr | output | ADDR_W | Row (activate) or opcode (load mode) |
| cmd_col | output | COL_W | Column of a read or write |
| cmd_ap | output | 1 | Auto-close flag of a read or write |
| cmd_all | output | 1 | Close-all flag of a bank close |
| cmd_bc4 | output | 1 | Four-beat chop selected |
| bank_open | output | 2**BA_W | Per-bank open-row bits |
| pd_mode | output | 2 | 0 none, 1 all banks idle, 2 row open |
| odt_en | output | 1 | Termination enable |
| mode_regs | output | 4*ADDR_W | Mode registers, register n at bits [n*ADDR_W +: ADDR_W] |

## Verification
Every decoded field, open-row bit, mode register, power-down code and the termination output is due at the first rising edge that samples the pins. The effect of a mode load on burst and termination appears one cycle later. The bench drives pins on the falling edge, advances its own model at the next rising edge and compares on the following falling edge, so each comparison lands exactly one edge after its stimulus. Directed sequences then cover the delayed mode effect, power-down entry in both flavours, commands ignored during power-down and exit, and a reset in the middle of a run.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_DES = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6,
    CMD_MRS = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PD_NONE = 2'd0,
    PD_IDLE = 2'd1,
    PD_OPEN = 2'd2
  } pd_e;

  localparam int NUM_MR   = 4;
  localparam int MR_BURST = 0;
  localparam int MR_TERM  = 1;

endpackage

// File: rtl/ddr_pin_decode.sv
module ddr_pin_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e kind
);

  always_comb begin
    if (cs_n) begin
      kind = CMD_DES;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  kind = CMD_MRS;
        3'b001:  kind = CMD_REF;
        3'b010:  kind = CMD_PRE;
        3'b011:  kind = CMD_ACT;
        3'b100:  kind = CMD_WR;
        3'b101:  kind = CMD_RD;
        default: kind = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_mode_store.sv
module ddr_mode_store
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [ADDR_W-1:0]        wr_data,
  output logic [NUM_MR*ADDR_W-1:0] mr_flat,
  output logic                     otf_en,
  output logic                     chop_fixed,
  output logic                     term_on
);

  localparam int TERM_B0 = 2;
  localparam int TERM_B1 = 6;
  localparam int TERM_B2 = 9;

  logic [ADDR_W-1:0] mr_q [NUM_MR];

  for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
    logic              load;
    logic [ADDR_W-1:0] mr_d;

    always_comb begin
      load = wr_en && (wr_sel == 2'(g));
      mr_d = load ? wr_data : mr_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mr_q[g] <= '0;
      else        mr_q[g] <= mr_d;
    end

    assign mr_flat[g*ADDR_W +: ADDR_W] = mr_q[g];
  end

  always_comb begin
    otf_en     = (mr_q[MR_BURST][1:0] == 2'b01);
    chop_fixed = (mr_q[MR_BURST][1:0] == 2'b10);
    term_on    = mr_q[MR_TERM][TERM_B0] | mr_q[MR_TERM][TERM_B1] |
                 mr_q[MR_TERM][TERM_B2];
  end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int BA_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_en,
  input  logic                 pre_en,
  input  logic                 pre_all,
  input  logic                 ap_close,
  input  logic [BA_W-1:0]      bank,
  output logic [(1<<BA_W)-1:0] open_q
);

  localparam int NBANK = 1 << BA_W;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit, set_b, clr_b, open_d;

    always_comb begin
      hit    = (bank == BA_W'(g));
      set_b  = act_en && hit;
      clr_b  = (pre_en && (pre_all || hit)) || (ap_close && hit);
      open_d = set_b ? 1'b1 : (clr_b ? 1'b0 : open_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q[g] <= 1'b0;
      else        open_q[g] <= open_d;
    end
  end

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BA_W   = 3,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic                      cke,
  input  logic                      odt,
  input  logic [BA_W-1:0]           ba,
  input  logic [ADDR_W-1:0]         addr,
  output logic [2:0]                cmd_kind,
  output logic [BA_W-1:0]           cmd_bank,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [COL_W-1:0]          cmd_col,
  output logic                      cmd_ap,
  output logic                      cmd_all,
  output logic                      cmd_bc4,
  output logic [(1<<BA_W)-1:0]      bank_open,
  output logic [1:0]                pd_mode,
  output logic                      odt_en,
  output logic [NUM_MR*ADDR_W-1:0]  mode_regs
);

  localparam int NBANK = 1 << BA_W;

  // reset: asserted at once, released through two flops
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_n, rs_meta} <= 2'b00;
    else        {rs_n, rs_meta} <= {rs_meta, 1'b1};
  end

  cmd_e kind_raw, kind_eff;
  logic accept, otf_en, chop_fixed, term_on;
  pd_e  pd_q, pd_d;

  ddr_pin_decode u_pins (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .kind  (kind_raw)
  );

  always_comb begin
    accept   = cke && (pd_q == PD_NONE);
    kind_eff = accept ? kind_raw : CMD_NOP;
  end

  ddr_mode_store #(.ADDR_W(ADDR_W)) u_modes (
    .clk        (clk),
    .rst_n      (rs_n),
    .wr_en      (kind_eff == CMD_MRS),
    .wr_sel     (ba[1:0]),
    .wr_data    (addr),
    .mr_flat    (mode_regs),
    .otf_en     (otf_en),
    .chop_fixed (chop_fixed),
    .term_on    (term_on)
  );

  ddr_bank_track #(.BA_W(BA_W)) u_banks (
    .clk      (clk),
    .rst_n    (rs_n),
    .act_en   (kind_eff == CMD_ACT),
    .pre_en   (kind_eff == CMD_PRE),
    .pre_all  (addr[AP_BIT]),
    .ap_close ((kind_eff == CMD_RD || kind_eff == CMD_WR) && addr[AP_BIT]),
    .bank     (ba),
    .open_q   (bank_open)
  );

  // next-state of the decoded command fields
  cmd_e              kind_q;
  logic [BA_W-1:0]   bank_d, bank_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [COL_W-1:0]  col_d, col_q;
  logic              ap_d, ap_q, all_d, all_q, bc4_d, bc4_q, odt_d, odt_q;

  always_comb begin
    bank_d = '0;
    addr_d = '0;
    col_d  = '0;
    ap_d   = 1'b0;
    all_d  = 1'b0;
    bc4_d  = 1'b0;
    case (kind_eff)
      CMD_ACT, CMD_MRS: begin
        bank_d = ba;
        addr_d = addr;
      end
      CMD_RD, CMD_WR: begin
        bank_d = ba;
        col_d  = addr[COL_W-1:0];
        ap_d   = addr[AP_BIT];
        bc4_d  = chop_fixed | (otf_en & ~addr[BC_BIT]);
      end
      CMD_PRE: begin
        bank_d = ba;
        all_d  = addr[AP_BIT];
      end
      default: ;
    endcase
    odt_d = odt & term_on;
  end

  // power-down tracking
  always_comb begin
    pd_d = pd_q;
    if (cke)                       pd_d = PD_NONE;
    else if (pd_q == PD_NONE)      pd_d = (|bank_open) ? PD_OPEN : PD_IDLE;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      kind_q <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      all_q  <= 1'b0;
      bc4_q  <= 1'b0;
      odt_q  <= 1'b0;
      pd_q   <= PD_NONE;
    end else begin
      kind_q <= kind_eff;
      bank_q <= bank_d;
      addr_q <= addr_d;
      col_q  <= col_d;
      ap_q   <= ap_d;
      all_q  <= all_d;
      bc4_q  <= bc4_d;
      odt_q  <= odt_d;
      pd_q   <= pd_d;
    end
  end

  assign cmd_kind = kind_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;
  assign cmd_col  = col_q;
  assign cmd_ap   = ap_q;
  assign cmd_all  = all_q;
  assign cmd_bc4  = bc4_q;
  assign pd_mode  = pd_q;
  assign odt_en   = odt_q;

endmodule

// File: rtl/ddr_cmd_decode_chk.sv
module ddr_cmd_decode_chk
  import ddr_cmd_pkg::*;
#(
  parameter int BA_W = 3
) (
  input logic                 clk,
  input logic                 rs_n,
  input logic                 cs_n,
  input logic                 cke,
  input logic                 odt,
  input logic [2:0]           cmd_kind,
  input logic [BA_W-1:0]      cmd_bank,
  input logic                 cmd_ap,
  input logic                 cmd_all,
  input logic [(1<<BA_W)-1:0] bank_open,
  input logic [1:0]           pd_mode,
  input logic                 odt_en
);

  a_r2_deselect: assert property (@(posedge clk) disable iff (!rs_n)
    (cs_n && cke && pd_mode == 2'd0) |=> (cmd_kind == 3'd1));

  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rs_n)
    (cmd_kind == 3'd2) |-> bank_open[cmd_bank]);

  a_r5_close_all: assert property (@(posedge clk) disable iff (!rs_n)
    (cmd_kind == 3'd5 && cmd_all) |-> (bank_open == '0));

  a_r6_auto_close: assert property (@(posedge clk) disable iff (!rs_n)
    ((cmd_kind == 3'd3 || cmd_kind == 3'd4) && cmd_ap) |-> !bank_open[cmd_bank]);

  a_r9_enter_idle: assert property (@(posedge clk) disable iff (!rs_n)
    (!cke && pd_mode == 2'd0 && bank_open == '0) |=> (pd_mode == 2'd1));

  a_r9_enter_open: assert property (@(posedge clk) disable iff (!rs_n)
    (!cke && pd_mode == 2'd0 && bank_open != '0) |=> (pd_mode == 2'd2));

  a_r9_exit: assert property (@(posedge clk) disable iff (!rs_n)
    cke |=> (pd_mode == 2'd0));

  a_r10_pd_ignores: assert property (@(posedge clk) disable iff (!rs_n)
    (pd_mode != 2'd0 || !cke) |=> (cmd_kind == 3'd0 && $stable(bank_open)));

  a_r11_odt_low: assert property (@(posedge clk) disable iff (!rs_n)
    !odt |=> !odt_en);

endmodule

bind ddr_cmd_decode ddr_cmd_decode_chk #(.BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rs_n      (rs_n),
  .cs_n      (cs_n),
  .cke       (cke),
  .odt       (odt),
  .cmd_kind  (cmd_kind),
  .cmd_bank  (cmd_bank),
  .cmd_ap    (cmd_ap),
  .cmd_all   (cmd_all),
  .bank_open (bank_open),
  .pd_mode   (pd_mode),
  .odt_en    (odt_en)
);

// File: tb/ddr_cmd_decode_test.sv
module ddr_cmd_decode_test;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                         C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst_n, cs_n, ras_n, cas_n, we_n, cke, odt;
  logic [2:0]  ba;
  logic [14:0] addr;
  logic [2:0]  cmd_kind, cmd_bank;
  logic [14:0] cmd_addr;
  logic [9:0]  cmd_col;
  logic        cmd_ap, cmd_all, cmd_bc4, odt_en;
  logic [7:0]  bank_open;
  logic [1:0]  pd_mode;
  logic [59:0] mode_regs;

  always #5 clk = ~clk;

  ddr_cmd_decode uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .odt(odt), .ba(ba), .addr(addr),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_all(cmd_all), .cmd_bc4(cmd_bc4),
    .bank_open(bank_open), .pd_mode(pd_mode), .odt_en(odt_en),
    .mode_regs(mode_regs)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state and expected outputs
  logic [14:0] m_mr [4];
  logic [7:0]  m_open;
  logic [1:0]  m_pd;
  logic [2:0]  e_kind, e_bank;
  logic [14:0] e_addr;
  logic [9:0]  e_col;
  logic        e_ap, e_all, e_bc4, e_odt, e_acc;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k, input logic acc);
    if (!acc) return "R10";
    case (k)
      3'd1:       return "R2";
      3'd2:       return "R4";
      3'd3, 3'd4: return "R6";
      3'd5:       return "R5";
      3'd7:       return "R8";
      default:    return "R3";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_mr[i] = '0;
    m_open = '0;
    m_pd   = '0;
  endtask

  task automatic model_step();
    logic [1:0] bl;
    e_acc  = cke && (m_pd == 2'd0);
    e_bank = '0; e_addr = '0; e_col = '0;
    e_ap = 1'b0; e_all = 1'b0; e_bc4 = 1'b0;
    e_odt  = odt && (m_mr[1][9] || m_mr[1][6] || m_mr[1][2]);
    if (!e_acc)    e_kind = 3'd0;
    else if (cs_n) e_kind = 3'd1;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  e_kind = 3'd7;
        3'b001:  e_kind = 3'd6;
        3'b010:  e_kind = 3'd5;
        3'b011:  e_kind = 3'd2;
        3'b100:  e_kind = 3'd4;
        3'b101:  e_kind = 3'd3;
        default: e_kind = 3'd0;
      endcase
    end
    bl = m_mr[0][1:0];
    case (e_kind)
      3'd2: begin e_bank = ba; e_addr = addr; m_open[ba] = 1'b1; end
      3'd3, 3'd4: begin
        e_bank = ba; e_col = addr[9:0]; e_ap = addr[10];
        e_bc4  = (bl == 2'b10) || (bl == 2'b01 && !addr[12]);
        if (addr[10]) m_open[ba] = 1'b0;
      end
      3'd5: begin
        e_bank = ba; e_all = addr[10];
        if (addr[10]) m_open = '0; else m_open[ba] = 1'b0;
      end
      3'd7: begin e_bank = ba; e_addr = addr; m_mr[ba[1:0]] = addr; end
      default: ;
    endcase
    if (!cke && m_pd == 2'd0) m_pd = (m_open != '0) ? 2'd2 : 2'd1;
    else if (cke)             m_pd = 2'd0;
  endtask

  task automatic compare_all();
    string t;
    t = tag_of(e_kind, e_acc);
    chk(t, "kind", 32'(cmd_kind), 32'(e_kind));
    chk(t, "bank", 32'(cmd_bank), 32'(e_bank));
    chk(t, "addr", 32'(cmd_addr), 32'(e_addr));
    chk(t, "col",  32'(cmd_col),  32'(e_col));
    chk(t, "ap",   32'(cmd_ap),   32'(e_ap));
    chk(t, "all",  32'(cmd_all),  32'(e_all));
    chk((e_kind == 3'd3 || e_kind == 3'd4) ? "R7" : t, "bc4",
        32'(cmd_bc4), 32'(e_bc4));
    chk(t, "open", 32'(bank_open), 32'(m_open));
    for (int i = 0; i < 4; i++)
      chk(e_acc ? "R8" : "R10", "mr", 32'(mode_regs[i*15 +: 15]), 32'(m_mr[i]));
    chk("R9",  "pd",  32'(pd_mode), 32'(m_pd));
    chk("R11", "odt", 32'(odt_en),  32'(e_odt));
  endtask

  // drive on a falling edge, model at the rising edge, compare on the next falling edge
  task automatic step(input logic [3:0] code, input logic ck, input logic od,
                      input logic [2:0] b, input logic [14:0] a);
    {cs_n, ras_n, cas_n, we_n} = code;
    cke = ck; odt = od; ba = b; addr = a;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic check_zero(input string what);
    chk("R1", {what, " kind"}, 32'(cmd_kind), 0);
    chk("R1", {what, " fields"},
        32'({cmd_bank, cmd_col, cmd_ap, cmd_all, cmd_bc4}), 0);
    chk("R1", {what, " addr"}, 32'(cmd_addr), 0);
    chk("R1", {what, " open"}, 32'(bank_open), 0);
    chk("R1", {what, " pd"},   32'(pd_mode), 0);
    chk("R1", {what, " odt"},  32'(odt_en), 0);
    chk("R1", {what, " mr"},   32'(mode_regs[31:0] | mode_regs[59:32]), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    cke = 1'b1; odt = 1'b1; ba = '0; addr = 15'h7fff;
    model_reset();
    repeat (3) @(negedge clk);
    check_zero("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_zero("sync window");
    @(negedge clk);

    // sweep every pin code over every bank (R2 R3 R4 R5 R6 R7 R8 R11)
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 8; b++)
        step(4'(c), 1'b1, 1'(b), 3'(b), 15'((c * 1237 + b * 389 + 77) & 32'h7fff));

    // burst selection (R7), effect of a mode load one cycle later (R8)
    step(C_PRE, 1, 0, 0, 15'h0400);
    step(C_MRS, 1, 0, 0, 15'h0001);
    step(C_RD,  1, 0, 3, 15'h1005);
    step(C_RD,  1, 0, 3, 15'h0006);
    step(C_WR,  1, 0, 4, 15'h0007);
    step(C_MRS, 1, 0, 0, 15'h0002);
    step(C_RD,  1, 0, 1, 15'h1008);
    step(C_MRS, 1, 0, 0, 15'h0003);
    step(C_WR,  1, 0, 1, 15'h0009);
    step(C_MRS, 1, 0, 0, 15'h0000);
    step(C_RD,  1, 0, 2, 15'h000a);

    // termination setting (R11)
    step(C_MRS, 1, 1, 1, 15'h0000);
    step(C_NOP, 1, 1, 0, 15'h0000);
    step(C_MRS, 1, 1, 1, 15'h0040);
    step(C_NOP, 1, 1, 0, 15'h0000);
    step(C_NOP, 1, 0, 0, 15'h0000);

    // open-row bookkeeping (R4 R5 R6)
    step(C_ACT, 1, 0, 2, 15'h1234);
    step(C_ACT, 1, 0, 5, 15'h4321);
    step(C_ACT, 1, 0, 7, 15'h7fff);
    step(C_PRE, 1, 0, 2, 15'h0000);
    step(C_RD,  1, 0, 5, 15'h0400);
    step(C_WR,  1, 0, 7, 15'h03ff);
    step(C_ACT, 1, 0, 2, 15'h0042);

    // power-down with a row open, ignored commands, exit (R9 R10)
    step(C_NOP, 0, 1, 0, 15'h0000);
    step(C_ACT, 0, 1, 6, 15'h0101);
    step(C_MRS, 0, 1, 2, 15'h5555);
    step(C_ACT, 1, 1, 6, 15'h0202);
    step(C_DES, 1, 1, 0, 15'h0000);
    // all banks idle power-down
    step(C_PRE, 1, 0, 0, 15'h0400);
    step(C_DES, 0, 0, 0, 15'h0000);
    step(C_PRE, 0, 0, 0, 15'h0000);
    step(C_MRS, 1, 0, 3, 15'h2222);
    step(C_MRS, 1, 0, 3, 15'h3333);

    // reset in the middle of a run (R1)
    step(C_ACT, 1, 1, 4, 15'h0abc);
    step(C_NOP, 0, 1, 0, 15'h0000);
    rst_n = 1'b0;
    #1;
    check_zero("mid-run");
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    step(C_ACT, 1, 0, 1, 15'h0011);
    step(C_NOP, 1, 0, 0, 15'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule